// File: doc/BRIEF.md
# Banked Interrupt Aggregator with Software Requests

This block gathers 64 already-conditioned interrupt lines into a single level-high request for a parent interrupt controller. Each line has an enable bit and a software request bit. A line is pending when its input is high or its software request is set. A pending line reaches the output only when its enable bit is set.

Software reaches the block through a plain 32-bit register port. The 64 lines are split into two 32-bit halves, and each half has the same group of six word registers. The upper group sits 0x18 bytes above the lower group.

Enables and software requests are never written directly. They change only through write-one-to-set and write-one-to-clear registers, so several agents can update them without a read-modify-write. The port has no stall: a write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high, and `bus_rdata` follows `bus_addr` combinationally in the same cycle.

Top module: `intr_route_bank`

## Requirements
- R1: After reset all enable bits and all software request bits are 0, every readable register returns 0 when all lines are low, and `irq_o` is low.
- R2: A write to enable-set (offset 0x08 in a group) sets each enable bit whose written bit is 1 and leaves the bits written as 0 unchanged.
- R3: A write to enable-clear (offset 0x0C) clears each enable bit whose written bit is 1 and leaves the others unchanged. Writing 0xFFFFFFFF disables all 32 lines of that half in a single write.
- R4: Software-set (offset 0x10) and software-clear (offset 0x14) update the software request bits with the same write-one semantics as the enables.
- R5: Raw status (offset 0x04) reads the line inputs ORed with the software request bits.
- R6: Status (offset 0x00) reads raw status ANDed with the enable bits.
- R7: Lines 0 to 31 map to the group at byte offset 0x00. Lines 32 to 63 map to the group at byte offset 0x18. Bit n of a word belongs to line n of its half.
- R8: `irq_o` is high exactly while at least one line is both pending and enabled. It is combinational in the current state and inputs.
- R9: Reading enable-set or enable-clear returns the current enable vector. Reading software-set or software-clear returns the current software request vector.
- R10: Writes to status, raw status, offsets that are not word offsets of a group, and addresses at or above 0x30 change no state. Those unused addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 64 | Conditioned interrupt lines, level high |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Level-high request to the parent controller |

## Verification
The bench writes zero bits alongside set bits, and a design that treated set or clear as a plain store would lose the bits it was told to keep. It clears all lines with one all-ones write. It drives the upper group at its shifted offset, where a wrong stride would land the update in the wrong half or in no half at all. It writes to read-only and unused addresses and then reads every register, which catches any decode that falls through into an update. Random line patterns are mixed with software requests and enables, so that a swapped OR and AND in the status path, or an output that ignores software requests, shows up on `irq_o` or in the status words.

// File: rtl/intr_bank_pkg.sv
package intr_bank_pkg;
  localparam int OFS_STAT   = 'h00;
  localparam int OFS_RAW    = 'h04;
  localparam int OFS_ENSET  = 'h08;
  localparam int OFS_ENCLR  = 'h0C;
  localparam int OFS_SWSET  = 'h10;
  localparam int OFS_SWCLR  = 'h14;
  localparam int GROUP_SPAN = 'h18;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_STAT,
    RG_RAW,
    RG_ENSET,
    RG_ENCLR,
    RG_SWSET,
    RG_SWCLR
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input int ofs);
    reg_sel_e s;
    case (ofs)
      OFS_STAT:  s = RG_STAT;
      OFS_RAW:   s = RG_RAW;
      OFS_ENSET: s = RG_ENSET;
      OFS_ENCLR: s = RG_ENCLR;
      OFS_SWSET: s = RG_SWSET;
      OFS_SWCLR: s = RG_SWCLR;
      default:   s = RG_NONE;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/intr_half_regs.sv
module intr_half_regs
  import intr_bank_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic [HALF_W-1:0] wdata,
  input  logic [HALF_W-1:0] line_i,
  output logic [HALF_W-1:0] en_q,
  output logic [HALF_W-1:0] soft_q,
  output logic [HALF_W-1:0] status,
  output logic [HALF_W-1:0] rdata
);
  logic [HALF_W-1:0] raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      soft_q <= '0;
    end else if (wr_en) begin
      case (sel)
        RG_ENSET: en_q   <= en_q | wdata;
        RG_ENCLR: en_q   <= en_q & ~wdata;
        RG_SWSET: soft_q <= soft_q | wdata;
        RG_SWCLR: soft_q <= soft_q & ~wdata;
        default: ;
      endcase
    end
  end

  assign raw    = line_i | soft_q;
  assign status = raw & en_q;

  always_comb begin
    case (sel)
      RG_STAT:            rdata = status;
      RG_RAW:             rdata = raw;
      RG_ENSET, RG_ENCLR: rdata = en_q;
      RG_SWSET, RG_SWCLR: rdata = soft_q;
      default:            rdata = '0;
    endcase
  end
endmodule

// File: rtl/intr_bank_collect.sv
module intr_bank_collect #(
  parameter int HALF_W     = 32,
  parameter int NUM_HALVES = 2
) (
  input  logic [NUM_HALVES-1:0][HALF_W-1:0] rdata_h,
  input  logic [NUM_HALVES-1:0][HALF_W-1:0] status_h,
  output logic [HALF_W-1:0]                 rdata,
  output logic                              irq
);
  always_comb begin
    rdata = '0;
    irq   = 1'b0;
    for (int h = 0; h < NUM_HALVES; h++) begin
      rdata = rdata | rdata_h[h];
      irq   = irq | (|status_h[h]);
    end
  end
endmodule

// File: rtl/intr_route_bank.sv
module intr_route_bank
  import intr_bank_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int HALF_W    = 32,
  parameter int ADDR_W    = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_i,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [HALF_W-1:0]    bus_wdata,
  output logic [HALF_W-1:0]    bus_rdata,
  output logic                 irq_o
);
  localparam int NUM_HALVES = NUM_LINES / HALF_W;

  logic [NUM_HALVES-1:0][HALF_W-1:0] rdata_h;
  logic [NUM_HALVES-1:0][HALF_W-1:0] status_h;
  logic [NUM_LINES-1:0]              en_all;
  logic [NUM_LINES-1:0]              soft_all;
  logic                              wr_en;

  assign wr_en = bus_sel & bus_wr;

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    localparam int BASE = h * GROUP_SPAN;
    int       ofs;
    logic     hit;
    reg_sel_e sel;

    assign ofs = int'(bus_addr) - BASE;
    assign hit = (int'(bus_addr) >= BASE) && (int'(bus_addr) < BASE + GROUP_SPAN);
    assign sel = hit ? decode_ofs(ofs) : RG_NONE;

    intr_half_regs #(.HALF_W(HALF_W)) u_half (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .sel    (sel),
      .wdata  (bus_wdata),
      .line_i (line_i[h*HALF_W +: HALF_W]),
      .en_q   (en_all[h*HALF_W +: HALF_W]),
      .soft_q (soft_all[h*HALF_W +: HALF_W]),
      .status (status_h[h]),
      .rdata  (rdata_h[h])
    );
  end

  intr_bank_collect #(.HALF_W(HALF_W), .NUM_HALVES(NUM_HALVES)) u_collect (
    .rdata_h  (rdata_h),
    .status_h (status_h),
    .rdata    (bus_rdata),
    .irq      (irq_o)
  );
endmodule

// File: rtl/intr_route_bank_chk.sv
module intr_route_bank_chk #(
  parameter int NUM_LINES = 64,
  parameter int HALF_W    = 32,
  parameter int ADDR_W    = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_sel,
  input logic                 bus_wr,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [HALF_W-1:0]    bus_wdata,
  input logic                 irq_o,
  input logic [NUM_LINES-1:0] en_all,
  input logic [NUM_LINES-1:0] soft_all
);
  logic wr;
  assign wr = bus_sel & bus_wr;

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !irq_o); // R1

  AST_ENSET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && int'(bus_addr) == 'h08) |=>
      ((en_all[HALF_W-1:0] & $past(bus_wdata)) == $past(bus_wdata))); // R2

  AST_ENCLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && int'(bus_addr) == 'h0C && bus_wdata == '1) |=>
      (en_all[HALF_W-1:0] == '0)); // R3

  AST_NO_EN_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (en_all == '0) |-> !irq_o); // R8

  AST_SOFT_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    ((soft_all & en_all) != '0) |-> irq_o); // R4

  AST_STATUS_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (int'(bus_addr) == 'h00 || int'(bus_addr) == 'h04)) |=>
      ($stable(en_all) && $stable(soft_all))); // R10
endmodule

bind intr_route_bank intr_route_bank_chk #(
  .NUM_LINES(NUM_LINES), .HALF_W(HALF_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq_o     (irq_o),
  .en_all    (en_all),
  .soft_all  (soft_all)
);

// File: tb/sim_intr_route_bank.sv
`timescale 1ns/1ps
module sim_intr_route_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] line_i = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int tests = 0;
  int fails = 0;
  logic [63:0] en_m = '0;
  logic [63:0] soft_m = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  intr_route_bank u0 (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  function automatic logic [31:0] exp_rd(input int a);
    int h;
    int off;
    logic [31:0] en_h, sw_h, ln_h, raw_h;
    if (a >= 'h30) return 32'h0;
    h    = (a >= 'h18) ? 1 : 0;
    off  = a - h * 'h18;
    en_h = en_m[h*32 +: 32];
    sw_h = soft_m[h*32 +: 32];
    ln_h = line_i[h*32 +: 32];
    raw_h = ln_h | sw_h;
    case (off)
      'h00: return raw_h & en_h;
      'h04: return raw_h;
      'h08, 'h0C: return en_h;
      'h10, 'h14: return sw_h;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic exp_irq();
    return |(en_m & (line_i | soft_m));
  endfunction

  task automatic model_wr(input int a, input logic [31:0] d);
    int h;
    int off;
    if (a >= 'h30) return;
    h   = (a >= 'h18) ? 1 : 0;
    off = a - h * 'h18;
    case (off)
      'h08: en_m[h*32 +: 32]   = en_m[h*32 +: 32] | d;
      'h0C: en_m[h*32 +: 32]   = en_m[h*32 +: 32] & ~d;
      'h10: soft_m[h*32 +: 32] = soft_m[h*32 +: 32] | d;
      'h14: soft_m[h*32 +: 32] = soft_m[h*32 +: 32] & ~d;
      default: ;
    endcase
  endtask

  task automatic do_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'(a); bus_wdata = d;
    model_wr(a, d);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic chk_rd(input int a, input string req);
    logic [31:0] e;
    bus_addr = 6'(a);
    #0.5;
    e = exp_rd(a);
    tests++;
    if (bus_rdata !== e) begin
      fails++;
      $display("FAIL %s addr=%02h actual=%08h expected=%08h", req, a, bus_rdata, e);
    end
  endtask

  task automatic chk_irq(input string req);
    logic e;
    #0.5;
    e = exp_irq();
    tests++;
    if (irq_o !== e) begin
      fails++;
      $display("FAIL %s irq actual=%0b expected=%0b", req, irq_o, e);
    end
  endtask

  task automatic chk_all(input string req);
    for (int a = 0; a < 'h40; a += 4) chk_rd(a, req);
    chk_irq(req);
  endtask

  initial begin
    #200000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4321));
    repeat (3) @(negedge clk);
    chk_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1");

    // R2: set some bits, then set more with zeros elsewhere
    do_wr('h08, 32'h0000_00F0); chk_rd('h08, "R2");
    do_wr('h08, 32'h0000_0003); chk_rd('h08, "R2"); chk_rd('h0C, "R9");
    line_i = 64'h0000_0000_0000_0010; chk_irq("R8"); chk_rd('h00, "R6");
    line_i = 64'h0000_0000_0000_0100; chk_irq("R8"); chk_rd('h04, "R5");
    // R3: partial clear, then all-ones clear
    do_wr('h0C, 32'h0000_0010); chk_rd('h08, "R3");
    do_wr('h0C, 32'hFFFF_FFFF); chk_rd('h08, "R3"); chk_irq("R3");
    // R4: software requests
    do_wr('h10, 32'h8000_0001); chk_rd('h10, "R4"); chk_rd('h14, "R9"); chk_irq("R4");
    do_wr('h08, 32'h8000_0000); chk_irq("R4"); chk_rd('h00, "R6");
    do_wr('h14, 32'h8000_0000); chk_rd('h10, "R4"); chk_irq("R4");
    // R7: upper group at 0x18
    line_i = 64'h0000_0004_0000_0000;
    do_wr('h20, 32'h0000_0004); chk_rd('h18, "R7"); chk_rd('h08, "R7"); chk_irq("R7");
    do_wr('h28, 32'h0001_0000); chk_rd('h2C, "R7"); chk_rd('h1C, "R7");
    do_wr('h24, 32'hFFFF_FFFF); chk_rd('h20, "R7"); chk_rd('h08, "R7");
    // R10: writes to read-only / unused addresses
    do_wr('h00, 32'hFFFF_FFFF); do_wr('h04, 32'hFFFF_FFFF);
    do_wr('h18, 32'hFFFF_FFFF); do_wr('h30, 32'hFFFF_FFFF);
    do_wr('h3C, 32'hFFFF_FFFF); do_wr('h09, 32'hFFFF_FFFF);
    chk_all("R10");
    chk_rd('h31, "R10"); chk_rd('h02, "R10");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int a;
      logic [31:0] d;
      d = $urandom();
      a = ($urandom() % 12) * 4;
      if ($urandom() % 8 == 0) a = $urandom() % 64;
      if ($urandom() % 4 == 0) line_i = {$urandom(), $urandom()} & {$urandom(), $urandom()};
      do_wr(a, d);
      chk_rd(($urandom() % 16) * 4, "R6");
      chk_irq("R8");
    end
    chk_all("R5");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule